// File: doc/BRIEF.md
# Five-Level Stacked-Carrier PWM Gate Generator

This block produces the switch commands for a three-phase, five-level diode-clamped inverter. Each phase receives a signed reference sample every clock. The block compares that sample against four triangular carriers. The carriers are stacked one above another, so together they cover the whole signed reference range. The number of carriers the reference exceeds picks one of five output levels. Each level is then translated into the eight switch commands of that phase leg, which gives 24 registered gate outputs in total.

All three phases share one carrier set. That set comes from a single up/down ramp counter. The step input sets how far the ramp moves per clock tick, and this sets the carrier period. For example, a 1200 Hz carrier against a 50 Hz reference gives a frequency ratio of 24. Dead time, capacitor balancing and closed-loop control belong to other blocks.

Top module: `pwm5_modulator`

## Requirements
- R1: Each 8-bit leg output is always one of five patterns: 8'h0F, 8'h1E, 8'h3C, 8'h78 or 8'hF0. Bit 7 is switch 1 and bit 0 is switch 8, and exactly four adjacent switches conduct.
- R2: In every leg, bits [7:4] always equal the bitwise inverse of bits [3:0]. That is, switch n is the complement of switch n+4.
- R3: While the synchronous active-high reset is sampled high, every leg takes the zero-level pattern 8'h3C at that edge. The ramp also returns to 0 in its rising direction.
- R4: With REF_W-bit references and B = 2^(REF_W-2), carrier k (k = 0..3) equals -2^(REF_W-1) + k*B + ramp. The level count c is the number of carriers strictly below the reference, and the leg pattern is 8'h0F shifted left by c.
- R5: A reference at the most negative code always gives 8'h0F, whatever the ramp value.
- R6: The ramp starts at 0 and rises. Each clock it moves by the step input. On the way up it clamps at B-1 and turns down. On the way down it clamps at 0 and turns up.
- R7: A step of zero freezes the ramp, so constant references give constant gate outputs.
- R8: The three phases use the same ramp, and each phase is driven only by its own reference.
- R9: Each gate output reflects the reference and ramp values sampled at the previous clock edge. The latency is exactly one register.
- R10: For a given ramp value, a larger reference never gives a lower level. Between two phases, the phase with the greater-or-equal reference shows an equal or higher pattern value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| car_step | input | REF_W-2 | Ramp increment per clock; sets the carrier period |
| ref_a | input | REF_W | Signed reference, phase a |
| ref_b | input | REF_W | Signed reference, phase b |
| ref_c | input | REF_W | Signed reference, phase c |
| gate_a | output | 8 | Switch commands, phase a (bit 7 = switch 1) |
| gate_b | output | 8 | Switch commands, phase b |
| gate_c | output | 8 | Switch commands, phase c |

## Verification
The ramp counter is the only hidden state. A wrong ramp value or a wrong direction shows up as a wrong level on any leg whose reference sits within a band. The error appears on the first edge after the ramp diverges, because each gate is one register away from the comparison. References placed near the top of each band expose clamping faults at the turn-around cycles. A frozen-carrier sweep reveals a comparator or encoding fault as a non-monotonic or illegal pattern within one cycle.

// File: rtl/pwm5_pkg.sv
package pwm5_pkg;

    localparam int LEG_SW  = 8;
    localparam int CARRIERS = 4;

    typedef logic [LEG_SW-1:0] leg_pat_t;

    localparam leg_pat_t PAT_LOWEST = 8'h0F;
    localparam leg_pat_t PAT_ZERO   = 8'h3C;

    // Level count 0..4 maps to four adjacent conducting switches.
    function automatic leg_pat_t level_to_pattern(input logic [2:0] cnt);
        return PAT_LOWEST << cnt;
    endfunction

endpackage

// File: rtl/pwm5_ramp.sv
module pwm5_ramp #(
    parameter int BAND_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BAND_W-1:0] step_i,
    output logic [BAND_W-1:0] ramp_o
);
    localparam logic [BAND_W:0] RAMP_TOP = {1'b0, {BAND_W{1'b1}}};

    typedef struct packed {
        logic [BAND_W-1:0] ramp;
        logic              rising;
    } ramp_st_t;

    ramp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.ramp   = '0;
            st_d.rising = 1'b1;
        end else if (st_q.rising) begin
            if (({1'b0, st_q.ramp} + {1'b0, step_i}) >= RAMP_TOP) begin
                st_d.ramp   = RAMP_TOP[BAND_W-1:0];
                st_d.rising = 1'b0;
            end else begin
                st_d.ramp = st_q.ramp + step_i;
            end
        end else begin
            if (st_q.ramp <= step_i) begin
                st_d.ramp   = '0;
                st_d.rising = 1'b1;
            end else begin
                st_d.ramp = st_q.ramp - step_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ramp_o = st_q.ramp;

endmodule

// File: rtl/pwm5_leg.sv
module pwm5_leg
    import pwm5_pkg::*;
#(
    parameter int REF_W = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [REF_W-1:0] ref_i,
    input  logic [REF_W-3:0]        ramp_i,
    output leg_pat_t                gate_o
);
    localparam int BAND_W = REF_W - 2;

    typedef struct packed {
        leg_pat_t gate;
    } leg_st_t;

    leg_st_t st_d, st_q;

    // Offset-binary view of the reference: 0 is the most negative code.
    logic [REF_W-1:0]    ref_ob;
    logic [CARRIERS-1:0] above;
    logic [2:0]          level_cnt;

    assign ref_ob = {~ref_i[REF_W-1], ref_i[REF_W-2:0]};

    for (genvar k = 0; k < CARRIERS; k++) begin : g_cmp
        localparam logic [1:0] BAND_IDX = 2'(k);
        logic [REF_W-1:0] carrier_ob;
        assign carrier_ob = {BAND_IDX, ramp_i[BAND_W-1:0]};
        assign above[k]   = ref_ob > carrier_ob;
    end

    always_comb begin
        level_cnt = '0;
        for (int k = 0; k < CARRIERS; k++) begin
            level_cnt = level_cnt + 3'(above[k]);
        end
    end

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.gate = PAT_ZERO;
        end else begin
            st_d.gate = level_to_pattern(level_cnt);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign gate_o = st_q.gate;

endmodule

// File: rtl/pwm5_modulator.sv
module pwm5_modulator
    import pwm5_pkg::*;
#(
    parameter int REF_W = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [REF_W-3:0]        car_step,
    input  logic signed [REF_W-1:0] ref_a,
    input  logic signed [REF_W-1:0] ref_b,
    input  logic signed [REF_W-1:0] ref_c,
    output logic [LEG_SW-1:0]       gate_a,
    output logic [LEG_SW-1:0]       gate_b,
    output logic [LEG_SW-1:0]       gate_c
);
    localparam int BAND_W = REF_W - 2;
    localparam int PHASES = 3;

    logic [BAND_W-1:0]       car_ramp;
    logic signed [REF_W-1:0] ref_arr  [PHASES];
    leg_pat_t                gate_arr [PHASES];

    assign ref_arr[0] = ref_a;
    assign ref_arr[1] = ref_b;
    assign ref_arr[2] = ref_c;

    pwm5_ramp #(.BAND_W(BAND_W)) u_ramp (
        .clk    (clk),
        .rst    (rst),
        .step_i (car_step),
        .ramp_o (car_ramp)
    );

    for (genvar p = 0; p < PHASES; p++) begin : g_phase
        pwm5_leg #(.REF_W(REF_W)) u_leg (
            .clk    (clk),
            .rst    (rst),
            .ref_i  (ref_arr[p]),
            .ramp_i (car_ramp),
            .gate_o (gate_arr[p])
        );
    end

    assign gate_a = gate_arr[0];
    assign gate_b = gate_arr[1];
    assign gate_c = gate_arr[2];

endmodule

// File: rtl/pwm5_modulator_chk.sv
module pwm5_modulator_chk #(
    parameter int REF_W = 12
) (
    input logic                    clk,
    input logic                    rst,
    input logic [REF_W-3:0]        car_step,
    input logic [REF_W-3:0]        car_ramp,
    input logic signed [REF_W-1:0] ref_a,
    input logic signed [REF_W-1:0] ref_b,
    input logic [7:0]              gate_a,
    input logic [7:0]              gate_b,
    input logic [7:0]              gate_c
);
    localparam logic signed [REF_W-1:0] REF_MIN = {1'b1, {(REF_W-1){1'b0}}};

    function automatic logic legal(input logic [7:0] g);
        return (g == 8'h0F) || (g == 8'h1E) || (g == 8'h3C) ||
               (g == 8'h78) || (g == 8'hF0);
    endfunction

    // R1: only the five adjacent-four patterns appear
    p_legal_r1: assert property (@(posedge clk) disable iff (rst)
        legal(gate_a) && legal(gate_b) && legal(gate_c));

    // R2: upper half mirrors inverted lower half
    p_compl_r2: assert property (@(posedge clk) disable iff (rst)
        (gate_a[7:4] == ~gate_a[3:0]) && (gate_b[7:4] == ~gate_b[3:0]) &&
        (gate_c[7:4] == ~gate_c[3:0]));

    // R5: most negative reference always yields the lowest pattern
    p_min_ref_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ref_a) == REF_MIN) |-> gate_a == 8'h0F);

    // R7: zero step holds the ramp still
    p_freeze_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(car_step) == '0) |-> car_ramp == $past(car_ramp));

    // R10: shared carrier keeps phase ordering
    p_order_r10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ref_a) >= $past(ref_b)) |-> gate_a >= gate_b);

endmodule

bind pwm5_modulator pwm5_modulator_chk #(.REF_W(REF_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .car_step (car_step),
    .car_ramp (car_ramp),
    .ref_a    (ref_a),
    .ref_b    (ref_b),
    .gate_a   (gate_a),
    .gate_b   (gate_b),
    .gate_c   (gate_c)
);

// File: tb/pwm5_modulator_tb.sv
`timescale 1ns/1ps
module pwm5_modulator_tb;
    localparam int REF_W  = 12;
    localparam int BAND   = 1 << (REF_W - 2);
    localparam int RMIN   = -(1 << (REF_W - 1));
    localparam int RMAX   = (1 << (REF_W - 1)) - 1;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic [REF_W-3:0]        car_step = '0;
    logic signed [REF_W-1:0] rv [3];
    logic [7:0]              gate_a, gate_b, gate_c;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    int ramp_m   = 0;
    bit rising_m = 1'b1;

    always #2 clk = ~clk;

    pwm5_modulator #(.REF_W(REF_W)) u_dut (
        .clk(clk), .rst(rst), .car_step(car_step),
        .ref_a(rv[0]), .ref_b(rv[1]), .ref_c(rv[2]),
        .gate_a(gate_a), .gate_b(gate_b), .gate_c(gate_c)
    );

    function automatic logic [7:0] exp_pat(input int r, input int rampv);
        int c = 0;
        for (int k = 0; k < 4; k++) begin
            if (r > RMIN + k * BAND + rampv) c++;
        end
        return 8'h0F << c;
    endfunction

    function automatic int level_of(input logic [7:0] g);
        for (int c = 0; c < 5; c++) begin
            if (g == (8'h0F << c)) return c;
        end
        return -1;
    endfunction

    function automatic logic [7:0] gate_of(input int p);
        return (p == 0) ? gate_a : (p == 1) ? gate_b : gate_c;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock: predict, advance model, then compare at the falling edge.
    task automatic tick(input string tag);
        logic [7:0] exp_g [3];
        for (int p = 0; p < 3; p++) begin
            exp_g[p] = rst ? 8'h3C : exp_pat(int'(rv[p]), ramp_m);
        end
        if (rst) begin
            ramp_m = 0; rising_m = 1'b1;
        end else if (rising_m) begin
            if (ramp_m + int'(car_step) >= BAND - 1) begin
                ramp_m = BAND - 1; rising_m = 1'b0;
            end else ramp_m = ramp_m + int'(car_step);
        end else begin
            if (ramp_m <= int'(car_step)) begin
                ramp_m = 0; rising_m = 1'b1;
            end else ramp_m = ramp_m - int'(car_step);
        end
        @(posedge clk);
        @(negedge clk);
        for (int p = 0; p < 3; p++) begin
            logic [7:0] g;
            g = gate_of(p);
            chk(g == exp_g[p], $sformatf("%s R4 R9 phase%0d", tag, p), g, exp_g[p]);
            chk(level_of(g) >= 0, $sformatf("R1 phase%0d legal", p), g, 8'h3C);
            chk(g[7:4] == ~g[3:0], $sformatf("R2 phase%0d complement", p), g[7:4], ~g[3:0]);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; rv[0] = 12'sd900; rv[1] = -12'sd900; rv[2] = 12'sd2000;
        car_step = 10'd200;
        repeat (3) tick("R3 reset");
        chk(gate_a == 8'h3C, "R3 zero pattern a", gate_a, 8'h3C);
        chk(gate_c == 8'h3C, "R3 zero pattern c", gate_c, 8'h3C);
        rst = 1'b0;
    endtask

    task automatic t_bands();
        car_step = 10'd300;
        rv[0] = -12'sd1500; rv[1] = 12'sd100; rv[2] = 12'sd1900;
        repeat (40) tick("R4 bands");
        rv[0] = 12'sd1500; rv[1] = -12'sd100;
        repeat (20) tick("R9 ref change");
    endtask

    task automatic t_carrier();
        car_step = 10'd300;
        rv[0] = 12'(RMIN + 950);
        rv[1] = 12'(RMIN + BAND + 950);
        rv[2] = 12'(RMIN + 3 * BAND + 950);
        repeat (30) tick("R6 ramp shape");
        car_step = 10'd7;
        repeat (300) tick("R6 slow ramp");
    endtask

    task automatic t_extreme();
        car_step = 10'd97;
        rv[0] = 12'(RMIN); rv[1] = 12'(RMAX); rv[2] = 12'sd0;
        for (int i = 0; i < 40; i++) begin
            tick("R5 extremes");
            chk(gate_a == 8'h0F, "R5 min ref lowest", gate_a, 8'h0F);
        end
    endtask

    task automatic t_freeze();
        logic [7:0] first;
        car_step = 10'd0;
        rv[0] = 12'sd333; rv[1] = -12'sd700; rv[2] = 12'sd1100;
        tick("R7 freeze");
        first = gate_a;
        repeat (20) begin
            tick("R7 freeze");
            chk(gate_a == first, "R7 frozen output", gate_a, first);
        end
    endtask

    task automatic t_sweep();
        int prev_a = 0;
        int prev_b = 4;
        car_step = 10'd0;
        for (int i = 0; i < 100; i++) begin
            rv[0] = 12'(RMIN + i * 41);
            rv[1] = 12'(RMAX - i * 41);
            rv[2] = 12'sd0;
            tick("R8 R10 sweep");
            chk(level_of(gate_a) >= prev_a, "R10 rising ref level", level_of(gate_a), prev_a);
            chk(level_of(gate_b) <= prev_b, "R10 falling ref level", level_of(gate_b), prev_b);
            prev_a = level_of(gate_a);
            prev_b = level_of(gate_b);
        end
    endtask

    task automatic t_reset_mid();
        car_step = 10'd150;
        rv[0] = 12'(RMIN + 500); rv[1] = 12'(RMIN + 2 * BAND + 100); rv[2] = -12'sd5;
        repeat (13) tick("R6 pre reset");
        rst = 1'b1;
        tick("R3 mid reset");
        rst = 1'b0;
        repeat (20) tick("R3 ramp restart");
    endtask

    initial begin
        rv[0] = '0; rv[1] = '0; rv[2] = '0;
        @(negedge clk);
        t_reset();
        t_bands();
        t_carrier();
        t_extreme();
        t_freeze();
        t_sweep();
        t_reset_mid();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule